// File: doc/BRIEF.md
# Transmit Descriptor Poll Engine

This block moves outgoing frames from host memory to a byte stream. Software builds a ring of 16-byte descriptors in memory. It places the ring at an address aligned to 256 bytes and then writes a doorbell byte with the poll bit set. The engine walks the ring from its current position. For each descriptor that software has handed to hardware, it reads the referenced buffer through a 32-bit word memory port and sends the bytes out on a valid/ready stream with a last marker. It then gives the descriptor back by rewriting its status word with the ownership bit cleared.

Each descriptor holds four 32-bit words: status at offset 0, a tag word at offset 4, the buffer address at offset 8 and an upper address word at offset 12. Within the status word, bit 31 is ownership, bit 30 ends the ring, bit 29 marks the first segment and bit 28 marks the last segment. Bits 12:0 give the byte count. The ring position survives between polls. Processing stops at the first descriptor that hardware does not own.

Top module: `tx_desc_poll_engine`

## Requirements
- R1: While reset is asserted and after it is released, the block issues no memory request, presents no stream byte and keeps frame_done low until a poll arrives. The fetch position starts at descriptor 0.
- R2: A doorbell write starts processing only when bit 6 of the written byte is 1. A write with bit 6 at 0 causes no memory access and no stream output.
- R3: Descriptor n lives at {ring_base, 8'h00} + 16*n. The engine reads only the status word (offset 0) and the buffer address word (offset 8), and never reads offsets 4 or 12.
- R4: When a fetched status word has bit 31 at 0, the engine writes nothing back, streams nothing, and stays idle until the next poll. The next poll starts again at that same descriptor.
- R5: For an owned descriptor, the engine streams status[12:0] bytes that start at the buffer byte address. That address may have any alignment. Bytes are taken from memory words in little-endian order, so byte address a comes from bits 8*(a mod 4)+7 : 8*(a mod 4).
- R6: A frame whose count is below 60 is sent as exactly 60 bytes. Bytes past the count are 0, and no memory read is made for them.
- R7: m_tlast is 1 on the final byte of a frame exactly when status bit 28 is 1. It is 0 on every other byte.
- R8: After a frame's final byte, the engine writes the fetched status word back to offset 0 of its descriptor with bit 31 cleared and every other bit unchanged. frame_done then pulses high for one cycle.
- R9: After a descriptor whose status bit 30 is 1, the next fetch is descriptor 0. Otherwise the next fetch is the following descriptor.
- R10: A poll that arrives while the engine is busy is remembered. Once the engine stops on an unowned descriptor, it fetches that descriptor's status once more.
- R11: A stream byte that is not accepted holds m_tvalid, m_tdata and m_tlast steady. A memory request that is not acknowledged holds its address, direction and write data steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_we | input | 1 | Doorbell byte write strobe |
| poll_data | input | 8 | Doorbell byte; bit 6 requests processing |
| ring_base | input | 24 | Ring address bits 31:8 (ring is 256-byte aligned) |
| mem_req | output | 1 | Memory transaction request, held until acknowledged |
| mem_we | output | 1 | 1 = word write, 0 = word read |
| mem_addr | output | 32 | Byte address of the word, always word aligned |
| mem_wdata | output | 32 | Write data (status write-back) |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Transaction completes on a clock edge where req and ack are both 1 |
| m_tvalid | output | 1 | Stream byte valid |
| m_tready | input | 1 | Stream byte accepted |
| m_tdata | output | 8 | Stream byte |
| m_tlast | output | 1 | Final byte of a frame with the last-segment bit |
| frame_done | output | 1 | One-cycle pulse per returned descriptor |

## Verification
Directed rings come first. One is a doorbell byte with bit 6 clear. Another is a lone owned descriptor, which shows that processing stops at the next unowned entry. A pair of short and odd-offset buffers tells padding and byte-lane selection apart from plain copying. A wrap case re-arms descriptor 0 behind an end-of-ring entry, and a second poll during a long frame shows the remembered request as an extra status read. Random rounds then arm the whole ring with random counts, offsets, last-segment bits and spare status bits, all under random stream back-pressure and random memory acknowledge delay. The bench compares the byte order, the last markers and the written-back status words with values it builds from its own copy of memory.

// File: rtl/tx_desc_poll_engine.sv
module tx_desc_poll_engine #(
  parameter int IDX_W    = 8,
  parameter int LEN_W    = 13,
  parameter int MIN_LEN  = 60,
  parameter int POLL_BIT = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        poll_we,
  input  logic [7:0]  poll_data,
  input  logic [31:8] ring_base,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  output logic        m_tvalid,
  input  logic        m_tready,
  output logic [7:0]  m_tdata,
  output logic        m_tlast,
  output logic        frame_done
);

  localparam int OWN_B = 31;
  localparam int EOR_B = 30;
  localparam int LS_B  = 28;
  localparam logic [7:0] POLL_MASK = 8'(1) << POLL_BIT;
  localparam logic [LEN_W-1:0] MIN_CNT = LEN_W'(MIN_LEN);

  typedef enum logic [2:0] {S_IDLE, S_STAT, S_BUF, S_DATA, S_WB} st_t;

  st_t              state;
  logic [IDX_W-1:0] idx;
  logic [31:0]      stat, ptr, word;
  logic [LEN_W-1:0] cnt;
  logic             word_ok, pend, done_q;

  wire              poll_hit  = poll_we && |(poll_data & POLL_MASK);
  wire [31:0]       desc_addr = {ring_base, 8'h00} + {{(28-IDX_W){1'b0}}, idx, 4'h0};
  wire [LEN_W-1:0]  len       = stat[LEN_W-1:0];
  wire [LEN_W-1:0]  total     = (len < MIN_CNT) ? MIN_CNT : len;
  wire              pad       = cnt >= len;
  wire              last_byte = cnt == total - 1'b1;
  wire [7:0]        lane      = word[{ptr[1:0], 3'b000} +: 8];
  wire              xfer      = m_tvalid && m_tready;
  wire              mem_done  = mem_req && mem_ack;

  assign m_tvalid   = (state == S_DATA) && (word_ok || pad);
  assign m_tdata    = pad ? 8'h00 : lane;
  assign m_tlast    = m_tvalid && last_byte && stat[LS_B];
  assign mem_we     = state == S_WB;
  assign mem_wdata  = {1'b0, stat[30:0]};
  assign frame_done = done_q;

  always_comb begin
    mem_req  = 1'b0;
    mem_addr = desc_addr;
    case (state)
      S_STAT, S_WB: mem_req = 1'b1;
      S_BUF: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr | 32'h8;
      end
      S_DATA: begin
        mem_req  = !word_ok && !pad;
        mem_addr = {ptr[31:2], 2'b00};
      end
      default: mem_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      idx     <= '0;
      stat    <= '0;
      ptr     <= '0;
      word    <= '0;
      cnt     <= '0;
      word_ok <= 1'b0;
      pend    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (poll_hit && state != S_IDLE) pend <= 1'b1;
      case (state)
        S_IDLE:
          if (poll_hit || pend) begin
            state <= S_STAT;
            pend  <= 1'b0;
          end
        S_STAT:
          if (mem_done) begin
            stat  <= mem_rdata;
            state <= mem_rdata[OWN_B] ? S_BUF : S_IDLE;
          end
        S_BUF:
          if (mem_done) begin
            ptr     <= mem_rdata;
            cnt     <= '0;
            word_ok <= 1'b0;
            state   <= S_DATA;
          end
        S_DATA: begin
          if (mem_done) begin
            word    <= mem_rdata;
            word_ok <= 1'b1;
          end
          if (xfer) begin
            ptr <= ptr + 32'd1;
            cnt <= cnt + 1'b1;
            if (ptr[1:0] == 2'b11) word_ok <= 1'b0;
            if (last_byte) state <= S_WB;
          end
        end
        S_WB:
          if (mem_done) begin
            done_q <= 1'b1;
            idx    <= stat[EOR_B] ? '0 : idx + 1'b1;
            state  <= S_STAT;
          end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_stream_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));

  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_done_after_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_done) |-> $past(mem_req && mem_ack && mem_we));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  assert_wb_status_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_addr[3:0] == 4'h0);

  assert_gap_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_tready && m_tlast |=> !m_tvalid);

endmodule

// File: tb/tb_tx_desc_poll_engine.sv
module tb_tx_desc_poll_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        poll_we = 1'b0;
  logic [7:0]  poll_data = 8'h00;
  logic [31:8] ring_base = 24'h000004;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 32'h0;
  logic        m_tvalid, m_tready = 1'b0, m_tlast, frame_done;
  logic [7:0]  m_tdata;

  tx_desc_poll_engine dut (
    .clk(clk), .rst_n(rst_n), .poll_we(poll_we), .poll_data(poll_data),
    .ring_base(ring_base), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .m_tdata(m_tdata), .m_tlast(m_tlast), .frame_done(frame_done));

  always #10 clk = ~clk;

  localparam int RING_W = 256;
  logic [31:0] mem [0:2047];
  logic [31:0] sts [0:3];
  logic [31:0] bufs [0:3];
  logic [7:0]  exp_q[$], rx_q[$];
  bit          expl_q[$], rxl_q[$];
  int checks = 0, errors = 0;
  int done_cnt = 0, rd_cnt = 0, bad_rd = 0;
  int st_rd [0:3];
  int ready_pct = 70;

  function automatic logic [7:0] mb(input logic [31:0] a);
    logic [31:0] w;
    w = mem[a[12:2]];
    return w[{a[1:0], 3'b000} +: 8];
  endfunction

  task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    m_tready = ($urandom % 100) < ready_pct;
    if (m_tvalid && m_tready) begin
      rx_q.push_back(m_tdata);
      rxl_q.push_back(m_tlast);
    end
    if (frame_done) done_cnt++;
    mem_ack = mem_req && ($urandom % 4 != 0);
    if (mem_ack) begin
      if (mem_we) mem[mem_addr[12:2]] = mem_wdata;
      else begin
        mem_rdata = mem[mem_addr[12:2]];
        rd_cnt++;
        if (mem_addr >= 32'h400 && mem_addr < 32'h440) begin
          if (mem_addr[3:0] == 4'h0) st_rd[(mem_addr - 32'h400) >> 4]++;
          if (mem_addr[3:0] == 4'h4 || mem_addr[3:0] == 4'hC) bad_rd++;
        end
      end
    end
  end

  task automatic arm(input int i, input logic [31:0] st, input logic [31:0] b);
    sts[i] = st;
    bufs[i] = b;
    mem[RING_W + 4*i]     = st;
    mem[RING_W + 4*i + 1] = $urandom;
    mem[RING_W + 4*i + 2] = b;
    mem[RING_W + 4*i + 3] = $urandom;
  endtask

  task automatic add_exp(input int i);
    int len, n;
    len = int'(sts[i][12:0]);
    n = (len < 60) ? 60 : len;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(k < len ? mb(bufs[i] + 32'(k)) : 8'h00);
      expl_q.push_back((k == n - 1) && sts[i][28]);
    end
  endtask

  task automatic poll(input logic [7:0] v);
    @(negedge clk);
    poll_we = 1'b1;
    poll_data = v;
    @(negedge clk);
    poll_we = 1'b0;
  endtask

  task automatic finish_frames(input string tag, input int target);
    int mism, lmism;
    while (done_cnt < target) @(negedge clk);
    repeat (40) @(negedge clk);
    chk({tag, " R5 byte count"}, rx_q.size() == exp_q.size(), rx_q.size(), exp_q.size());
    mism = 0;
    lmism = 0;
    for (int k = 0; k < rx_q.size() && k < exp_q.size(); k++) begin
      if (rx_q[k] != exp_q[k]) mism++;
      if (rxl_q[k] != expl_q[k]) lmism++;
    end
    chk({tag, " R5 R6 data"}, mism == 0, mism, 0);
    chk({tag, " R7 tlast"}, lmism == 0, lmism, 0);
    chk({tag, " R8 done count"}, done_cnt == target, done_cnt, target);
    rx_q.delete(); rxl_q.delete(); exp_q.delete(); expl_q.delete();
  endtask

  task automatic chk_wb(input string tag, input int i);
    chk({tag, " R8 writeback"}, mem[RING_W + 4*i] == (sts[i] & 32'h7FFF_FFFF),
        mem[RING_W + 4*i], sts[i] & 32'h7FFF_FFFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int tgt, start;
    logic [31:0] st;
    void'($urandom(32'd7731));
    for (int a = 0; a < 2048; a++) mem[a] = $urandom;
    for (int a = RING_W; a < RING_W + 64; a++) mem[a] = 32'h0;
    for (int a = 0; a < 4; a++) st_rd[a] = 0;

    repeat (3) @(negedge clk);
    chk("R1 in reset req", mem_req == 1'b0, mem_req, 0);
    chk("R1 in reset valid", m_tvalid == 1'b0, m_tvalid, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 after reset", {mem_req, m_tvalid, frame_done} == 3'b000, {mem_req, m_tvalid, frame_done}, 0);

    // R2: poll bit clear is ignored
    arm(0, 32'hB000_0000 | 32'h0055_0000 | 32'd70, 32'h800);
    poll(8'hBF);
    repeat (40) @(negedge clk);
    chk("R2 no reads", rd_cnt == 0, rd_cnt, 0);
    chk("R2 no bytes", rx_q.size() == 0, rx_q.size(), 0);
    chk("R2 still owned", mem[RING_W][31] == 1'b1, mem[RING_W][31], 1);

    // R2/R4: real poll, single frame starting at descriptor 0 (R1), stop at 1
    add_exp(0);
    poll(8'h40);
    finish_frames("single", 1);
    chk_wb("single", 0);
    chk("R4 R3 stop read desc1", st_rd[1] == 1, st_rd[1], 1);
    chk("R4 no write to desc1", mem[RING_W + 4] == 32'h0, mem[RING_W + 4], 0);

    // R5/R6/R7: short unaligned frame without last bit, odd length with last bit
    arm(1, 32'hA000_0000 | 32'h0ABC_0000 | 32'd5, 32'hA03);
    arm(2, 32'hB000_0000 | 32'd61, 32'hC01);
    add_exp(1);
    add_exp(2);
    poll(8'h40);
    finish_frames("pad", 3);
    chk_wb("pad", 1);
    chk_wb("pad", 2);

    // R9/R4: end-of-ring wraps to re-armed descriptor 0, resumes at 3
    arm(3, 32'hF000_0000 | 32'd64, 32'hE02);
    arm(0, 32'hB000_0000 | 32'h0F00_0000 | 32'd8, 32'h902);
    add_exp(3);
    add_exp(0);
    poll(8'h41);
    finish_frames("wrap R9", 5);
    chk_wb("wrap", 3);
    chk_wb("wrap", 0);

    // R10: poll during a busy frame is remembered
    for (int a = 0; a < 4; a++) st_rd[a] = 0;
    arm(1, 32'hB000_0000 | 32'd200, 32'hA00);
    add_exp(1);
    ready_pct = 30;
    poll(8'h40);
    while (rx_q.size() < 3) @(negedge clk);
    poll(8'hC0);
    finish_frames("busy R10", 6);
    chk("R10 refetch desc2", st_rd[2] == 2, st_rd[2], 2);
    ready_pct = 70;

    // random rounds: whole ring, start index 2
    tgt = 6;
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 4; i++) begin
        st = 32'hA000_0000 | ({$urandom} & 32'h0FFF_E000) | 32'($urandom % 300);
        if ($urandom % 2) st[28] = 1'b1;
        if (i == 3) st[30] = 1'b1;
        arm(i, st, 32'h800 + 32'(i) * 32'h200 + 32'($urandom % 4));
      end
      start = 2;
      for (int k = 0; k < 4; k++) add_exp((start + k) % 4);
      tgt += 4;
      ready_pct = 40 + r * 20;
      poll(8'h40);
      finish_frames("random", tgt);
      for (int i = 0; i < 4; i++) chk_wb("random", i);
    end

    chk("R3 no tag/upper reads", bad_rd == 0, bad_rd, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule